// File: doc/BRIEF.md
# Page Buffer Column Pointer

This block keeps the byte pointer into a page buffer of 528 columns. The buffer is split into a lower half (columns 0 to 255), an upper half (256 to 511) and a 16-byte spare area (512 to 527). A read-mode command picks one of these three regions. The region stays selected until another read-mode command replaces it. A column byte taken during the address phase is mapped into the selected region and becomes the start pointer. Each falling edge of the active-low read strobe then moves the pointer forward by one column.

When the pointer sits on the last column of the page, a further strobe edge does one of two things. With sequencing enabled, it raises a one-cycle request for the next page, steps the page address and goes busy. With sequencing disabled, the pointer simply stays where it is. When the external transfer completes, the pointer restarts at the base of the page: column 512 for the spare region and column 0 otherwise. A page-size option shortens the page to 512 columns. The buffer storage and the array transfer itself belong to the surrounding logic.

Top module: `page_col_ptr`

## Requirements
- R1: While `rst` is high at a clock edge, the following outputs go to their reset values: `col_out` to 0, `region_out` to 0, `page_addr` to 0, `busy` to 0 and `page_req` to 0.
- R2: A `cmd_valid` cycle sets `region_out` as follows: code 8'h00 gives 0 (lower half), 8'h01 gives 1 (upper half) and 8'h50 gives 2 (spare). Any other code leaves `region_out` unchanged. The region stays in force until the next such command.
- R3: A `col_load` cycle sets the pointer using the region held before that cycle. In region 0 the pointer becomes `col_addr`, and in region 1 it becomes 256 + `col_addr`. When a load and a strobe edge arrive in the same cycle, the load wins.
- R4: In region 2, a `col_load` sets `col_out` to 512 + `col_addr[3:0]`. Bits 7 to 4 of `col_addr` have no effect.
- R5: A strobe edge is a 1-to-0 change of `rd_n` between two clock edges. It increments `col_out` by one at the clock edge where the low level is first sampled. Holding `rd_n` low advances the pointer only once.
- R6: The last column is 527 when `short_page` is 0 and 511 when it is 1.
- R7: With `seq_en` = 1, a strobe edge on the last column does three things at that clock edge: `page_req` goes high for exactly one cycle, `busy` goes high, and `page_addr` increments. `col_out` holds its value.
- R8: While `busy` is high, strobe edges, column loads, page loads and commands have no effect.
- R9: `xfer_done` while `busy` clears `busy`. In the same edge, `col_out` reloads to 512 in region 2 and to 0 in regions 0 and 1.
- R10: With `seq_en` = 0, strobe edges on the last column leave `col_out` there, and `busy` stays low.
- R11: Command 8'h50 is ignored while `short_page` is 1.
- R12: A `page_load` cycle while not busy sets `page_addr` to `page_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command byte present this cycle |
| cmd_code | input | 8 | Command byte |
| col_load | input | 1 | Column byte from the address phase present |
| col_addr | input | 8 | Column byte |
| page_load | input | 1 | Page address present |
| page_in | input | PAGE_W | Page address to load |
| rd_n | input | 1 | Read strobe, active low |
| short_page | input | 1 | 1 selects 512-column pages |
| seq_en | input | 1 | 1 rolls over into the next page at the last column |
| xfer_done | input | 1 | Array transfer finished |
| col_out | output | COL_W | Current column pointer |
| region_out | output | 2 | Selected region (0 lower, 1 upper, 2 spare) |
| busy | output | 1 | Waiting for a page transfer |
| page_req | output | 1 | One-cycle next-page request |
| page_addr | output | PAGE_W | Current page address |

## Verification
The pointer is loaded in each region and then stepped with separate strobe pulses, a strobe held low, and a load that coincides with a strobe edge. These cases separate true edge detection from level sensing and show which event takes priority. Runs to the last column are made with both page sizes and with sequencing on and off. They show the hold behaviour versus the rollover behaviour, and whether the reload lands on the spare base or on column 0. Commands, loads and strobes sent while busy, together with a spare-region command sent in short-page mode, show that the freeze and the mode guard have no side effects on any output.

// File: rtl/pgcp_pkg.sv
package pgcp_pkg;

    parameter int COL_W       = 10;
    parameter int HALF_COLS   = 256;
    parameter int MAIN_COLS   = 512;
    parameter int SPARE_COLS  = 16;
    localparam int SPARE_SEL_W = $clog2(SPARE_COLS);

    localparam logic [7:0] OP_LOWER = 8'h00;
    localparam logic [7:0] OP_UPPER = 8'h01;
    localparam logic [7:0] OP_SPARE = 8'h50;

    typedef enum logic [1:0] {
        REG_LOWER = 2'd0,
        REG_UPPER = 2'd1,
        REG_SPARE = 2'd2
    } region_e;

    typedef struct packed {
        logic                 load;
        logic                 step;
        logic                 reload;
        logic [7:0]           addr;
        logic [COL_W-1:0]     last;
    } col_ctl_t;

    function automatic logic [COL_W-1:0] last_col(input logic short_pg);
        return short_pg ? COL_W'(MAIN_COLS - 1) : COL_W'(MAIN_COLS + SPARE_COLS - 1);
    endfunction

    function automatic logic [COL_W-1:0] start_col(input region_e r, input logic [7:0] a);
        case (r)
            REG_UPPER: return COL_W'(HALF_COLS) + COL_W'(a);
            REG_SPARE: return COL_W'(MAIN_COLS) + COL_W'(a[SPARE_SEL_W-1:0]);
            default:   return COL_W'(a);
        endcase
    endfunction

    function automatic logic [COL_W-1:0] wrap_base(input region_e r);
        return (r == REG_SPARE) ? COL_W'(MAIN_COLS) : '0;
    endfunction

endpackage

// File: rtl/pgcp_region.sv
module pgcp_region
    import pgcp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       freeze,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    input  logic       short_page,
    output region_e    region
);

    always_ff @(posedge clk) begin
        if (rst) begin
            region <= REG_LOWER;
        end else if (cmd_valid && !freeze) begin
            case (cmd_code)
                OP_LOWER: region <= REG_LOWER;
                OP_UPPER: region <= REG_UPPER;
                OP_SPARE: if (!short_page) region <= REG_SPARE;
                default:  region <= region;
            endcase
        end
    end

endmodule

// File: rtl/pgcp_col_ctr.sv
module pgcp_col_ctr
    import pgcp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             freeze,
    input  region_e          region,
    input  col_ctl_t         ctl,
    output logic [COL_W-1:0] col
);

    logic at_end;
    assign at_end = (col == ctl.last);

    always_ff @(posedge clk) begin
        if (rst) begin
            col <= '0;
        end else if (ctl.reload) begin
            col <= wrap_base(region);
        end else if (!freeze) begin
            if (ctl.load) begin
                col <= start_col(region, ctl.addr);
            end else if (ctl.step && !at_end) begin
                col <= col + COL_W'(1);
            end
        end
    end

endmodule

// File: rtl/pgcp_seq.sv
module pgcp_seq #(
    parameter int PAGE_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wrap_hit,
    input  logic              xfer_done,
    input  logic              page_load,
    input  logic [PAGE_W-1:0] page_in,
    output logic              busy,
    output logic              page_req,
    output logic              reload,
    output logic [PAGE_W-1:0] page_addr
);

    assign reload = busy && xfer_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            page_req  <= 1'b0;
            page_addr <= '0;
        end else begin
            page_req <= wrap_hit;
            if (wrap_hit) begin
                busy      <= 1'b1;
                page_addr <= page_addr + PAGE_W'(1);
            end else if (reload) begin
                busy <= 1'b0;
            end else if (page_load && !busy) begin
                page_addr <= page_in;
            end
        end
    end

endmodule

// File: rtl/page_col_ptr.sv
module page_col_ptr
    import pgcp_pkg::*;
#(
    parameter int PAGE_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    input  logic              col_load,
    input  logic [7:0]        col_addr,
    input  logic              page_load,
    input  logic [PAGE_W-1:0] page_in,
    input  logic              rd_n,
    input  logic              short_page,
    input  logic              seq_en,
    input  logic              xfer_done,
    output logic [COL_W-1:0]  col_out,
    output logic [1:0]        region_out,
    output logic              busy,
    output logic              page_req,
    output logic [PAGE_W-1:0] page_addr
);

    logic     rd_q;
    logic     fall;
    logic     wrap_hit;
    logic     reload;
    region_e  region;
    col_ctl_t ctl;

    always_ff @(posedge clk) begin
        if (rst) rd_q <= 1'b1;
        else     rd_q <= rd_n;
    end

    assign fall     = rd_q && !rd_n;
    assign wrap_hit = fall && !busy && !col_load && seq_en
                      && (col_out == last_col(short_page));

    always_comb begin
        ctl.load   = col_load;
        ctl.step   = fall;
        ctl.reload = reload;
        ctl.addr   = col_addr;
        ctl.last   = last_col(short_page);
    end

    pgcp_region u_region (
        .clk        (clk),
        .rst        (rst),
        .freeze     (busy),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .short_page (short_page),
        .region     (region)
    );

    pgcp_col_ctr u_col (
        .clk    (clk),
        .rst    (rst),
        .freeze (busy),
        .region (region),
        .ctl    (ctl),
        .col    (col_out)
    );

    pgcp_seq #(.PAGE_W(PAGE_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .wrap_hit  (wrap_hit),
        .xfer_done (xfer_done),
        .page_load (page_load),
        .page_in   (page_in),
        .busy      (busy),
        .page_req  (page_req),
        .reload    (reload),
        .page_addr (page_addr)
    );

    assign region_out = region;

endmodule

// File: rtl/pgcp_chk.sv
module pgcp_chk
    import pgcp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             col_load,
    input logic             xfer_done,
    input logic [COL_W-1:0] col_out,
    input logic [1:0]       region_out,
    input logic             busy,
    input logic             page_req
);

    assert_req_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        page_req |=> !page_req);

    assert_req_busy_R7: assert property (@(posedge clk) disable iff (rst)
        page_req |-> busy);

    assert_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !xfer_done) |=> $stable(col_out));

    assert_single_step_R5: assert property (@(posedge clk) disable iff (rst)
        (!col_load && !(busy && xfer_done))
        |=> (col_out == $past(col_out) || col_out == $past(col_out) + 1'b1));

    assert_col_range_R6: assert property (@(posedge clk) disable iff (rst)
        col_out <= COL_W'(MAIN_COLS + SPARE_COLS - 1));

    assert_reload_base_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && xfer_done) |=> (col_out == '0 || col_out == COL_W'(MAIN_COLS)));

    assert_spare_load_R4: assert property (@(posedge clk) disable iff (rst)
        (region_out == 2'd2 && col_load && !busy)
        |=> (col_out >= COL_W'(MAIN_COLS)
             && col_out <= COL_W'(MAIN_COLS + SPARE_COLS - 1)));

endmodule

bind page_col_ptr pgcp_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .col_load   (col_load),
    .xfer_done  (xfer_done),
    .col_out    (col_out),
    .region_out (region_out),
    .busy       (busy),
    .page_req   (page_req)
);

// File: tb/test_page_col_ptr.sv
`timescale 1ns/1ps
module test_page_col_ptr;

    localparam int PW = 13;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_code = 8'h00;
    logic          col_load = 1'b0;
    logic [7:0]    col_addr = 8'h00;
    logic          page_load = 1'b0;
    logic [PW-1:0] page_in = '0;
    logic          rd_n = 1'b1;
    logic          short_page = 1'b0;
    logic          seq_en = 1'b0;
    logic          xfer_done = 1'b0;
    logic [9:0]    col_out;
    logic [1:0]    region_out;
    logic          busy;
    logic          page_req;
    logic [PW-1:0] page_addr;

    int n_run = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    int m_col = 0, m_reg = 0, m_page = 0, m_busy = 0, m_req = 0, m_rdq = 1;

    always #2 clk = ~clk;

    page_col_ptr #(.PAGE_W(PW)) i_page_col_ptr (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .col_load(col_load), .col_addr(col_addr), .page_load(page_load),
        .page_in(page_in), .rd_n(rd_n), .short_page(short_page), .seq_en(seq_en),
        .xfer_done(xfer_done), .col_out(col_out), .region_out(region_out),
        .busy(busy), .page_req(page_req), .page_addr(page_addr)
    );

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        int  lastc;
        bit  fall;
        bit  wrapped;
        if (rst) begin
            m_col = 0; m_reg = 0; m_page = 0; m_busy = 0; m_req = 0; m_rdq = 1;
        end else begin
            fall    = (m_rdq == 1) && !rd_n;
            wrapped = 1'b0;
            m_req   = 0;
            lastc   = short_page ? 511 : 527;
            if (m_busy != 0) begin
                if (xfer_done) begin
                    m_busy = 0;
                    m_col  = (m_reg == 2) ? 512 : 0;
                end
            end else begin
                if (col_load) begin
                    if (m_reg == 0)      m_col = int'(col_addr);
                    else if (m_reg == 1) m_col = 256 + int'(col_addr);
                    else                 m_col = 512 + (int'(col_addr) % 16);
                end else if (fall) begin
                    if (m_col == lastc) begin
                        if (seq_en) begin
                            m_busy = 1; m_req = 1; wrapped = 1'b1;
                            m_page = (m_page + 1) % (1 << PW);
                        end
                    end else begin
                        m_col = m_col + 1;
                    end
                end
                if (!wrapped && page_load) m_page = int'(page_in);
                if (cmd_valid) begin
                    if (cmd_code == 8'h00)                     m_reg = 0;
                    else if (cmd_code == 8'h01)                m_reg = 1;
                    else if (cmd_code == 8'h50 && !short_page) m_reg = 2;
                end
            end
            m_rdq = rd_n ? 1 : 0;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            n_run++;
            if (int'(col_out) != m_col) begin
                n_fail++; $display("FAIL R5 model col_out actual=%0d expected=%0d", col_out, m_col);
            end
            if (int'(region_out) != m_reg) begin
                n_fail++; $display("FAIL R2 model region_out actual=%0d expected=%0d", region_out, m_reg);
            end
            if (int'(busy) != m_busy) begin
                n_fail++; $display("FAIL R8 model busy actual=%0d expected=%0d", busy, m_busy);
            end
            if (int'(page_req) != m_req) begin
                n_fail++; $display("FAIL R7 model page_req actual=%0d expected=%0d", page_req, m_req);
            end
            if (int'(page_addr) != m_page) begin
                n_fail++; $display("FAIL R12 model page_addr actual=%0d expected=%0d", page_addr, m_page);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect_eq(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send_cmd(logic [7:0] c);
        cmd_valid = 1'b1; cmd_code = c; tick(); cmd_valid = 1'b0;
    endtask

    task automatic send_col(logic [7:0] a);
        col_load = 1'b1; col_addr = a; tick(); col_load = 1'b0;
    endtask

    task automatic strobe();
        rd_n = 1'b0; tick(); rd_n = 1'b1; tick();
    endtask

    task automatic end_xfer();
        xfer_done = 1'b1; tick(); xfer_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick(); tick();
        rst = 1'b0;
        cmp_on = 1'b1;
        // R1 reset state
        expect_eq("R1 col_out", int'(col_out), 0);
        expect_eq("R1 region_out", int'(region_out), 0);
        expect_eq("R1 busy", int'(busy), 0);
        expect_eq("R1 page_addr", int'(page_addr), 0);
        expect_eq("R1 page_req", int'(page_req), 0);

        // R2 region commands and stickiness
        send_cmd(8'h01); expect_eq("R2 upper", int'(region_out), 1);
        send_cmd(8'h50); expect_eq("R2 spare", int'(region_out), 2);
        send_cmd(8'h33); expect_eq("R2 unknown code ignored", int'(region_out), 2);
        send_cmd(8'h00); expect_eq("R2 lower", int'(region_out), 0);

        // R3 lower-half load, R5 stepping
        send_col(8'h37); expect_eq("R3 lower load", int'(col_out), 55);
        repeat (3) strobe();
        expect_eq("R5 three strobes", int'(col_out), 58);
        rd_n = 1'b0; tick(); tick(); tick();
        expect_eq("R5 held low steps once", int'(col_out), 59);
        rd_n = 1'b1; tick();
        expect_eq("R5 rising edge no step", int'(col_out), 59);

        // R3 upper-half load
        send_cmd(8'h01); send_col(8'h10);
        expect_eq("R3 upper load", int'(col_out), 272);
        // R3 load beats a coincident strobe edge
        rd_n = 1'b0; col_load = 1'b1; col_addr = 8'h20; tick(); col_load = 1'b0;
        expect_eq("R3 load wins over edge", int'(col_out), 288);
        rd_n = 1'b1; tick();

        // R4 spare region ignores upper address bits
        send_cmd(8'h50); send_col(8'hA5);
        expect_eq("R4 spare load", int'(col_out), 517);

        // R10 hold at last column, R6 528-page end
        seq_en = 1'b0;
        send_col(8'hFE);
        expect_eq("R4 spare load 14", int'(col_out), 526);
        strobe(); expect_eq("R6 last col 527", int'(col_out), 527);
        strobe(); expect_eq("R10 hold at end", int'(col_out), 527);
        expect_eq("R10 stays ready", int'(busy), 0);

        // R7 rollover request
        seq_en = 1'b1;
        rd_n = 1'b0; tick();
        expect_eq("R7 page_req high", int'(page_req), 1);
        expect_eq("R7 busy high", int'(busy), 1);
        expect_eq("R7 page incremented", int'(page_addr), 1);
        expect_eq("R7 col holds", int'(col_out), 527);
        rd_n = 1'b1; tick();
        expect_eq("R7 page_req one cycle", int'(page_req), 0);

        // R8 ignored while busy
        strobe();
        send_col(8'h00);
        send_cmd(8'h00);
        page_load = 1'b1; page_in = 13'h0042; tick(); page_load = 1'b0;
        expect_eq("R8 col frozen", int'(col_out), 527);
        expect_eq("R8 region frozen", int'(region_out), 2);
        expect_eq("R8 page frozen", int'(page_addr), 1);
        expect_eq("R8 still busy", int'(busy), 1);

        // R9 reload to spare base
        end_xfer();
        expect_eq("R9 busy cleared", int'(busy), 0);
        expect_eq("R9 spare base", int'(col_out), 512);

        // R6 512-page end, R9 base 0 for upper region
        short_page = 1'b1;
        send_cmd(8'h01);
        send_col(8'hFE); expect_eq("R3 upper 510", int'(col_out), 510);
        strobe(); expect_eq("R6 short last 511", int'(col_out), 511);
        strobe();
        expect_eq("R6 short page wraps", int'(busy), 1);
        expect_eq("R7 page 2", int'(page_addr), 2);
        end_xfer();
        expect_eq("R9 base zero", int'(col_out), 0);

        // R11 spare command blocked in short mode
        send_cmd(8'h50);
        expect_eq("R11 spare blocked", int'(region_out), 1);

        // R6 511 is not the end in long mode
        short_page = 1'b0; seq_en = 1'b0;
        send_col(8'hFF); strobe();
        expect_eq("R6 long passes 511", int'(col_out), 512);

        // R12 page load
        page_load = 1'b1; page_in = 13'h0123; tick(); page_load = 1'b0;
        expect_eq("R12 page load", int'(page_addr), 291);

        // R1 reset again mid-run
        rst = 1'b1; tick(); rst = 1'b0;
        expect_eq("R1 col after reset", int'(col_out), 0);
        expect_eq("R1 page after reset", int'(page_addr), 0);
        tick(); tick();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule